// File: doc/BRIEF.md
# Masked Connection Lookup CAM

This block is a small content-addressable store of switching connection entries. Each line holds a path identifier (VPI), a channel identifier (VCI) and a valid flag. A processor-style command port accepts four kinds of work: three search flavours that differ in which fields take part in the compare, and a line write. A fifth command loads the mode register. Searches report the lowest matching line index and a hit bit. A write can first check that its pattern is not already present anywhere, both in the local lines and through a match input from an optional second store. It can also check that it does not overwrite an occupied line. Either check aborts the write and sets a status failure bit.

Each enabled write check adds one cycle to the command. A busy flag covers the whole command. A request that arrives while busy is dropped. A one-cycle done pulse marks the moment the status outputs carry the result.

Top module: `conn_cam`

## Requirements
- R1: After reset, busy_o, done_o, hit_o, dup_fail_o and occ_fail_o are 0. Every line is invalid with VPI and VCI zero. The mode register holds 5'b00100.
- R2: A request is taken when req_valid_i is 1 and busy_o is 0. req_op_i selects the command: 1 is search type 1, 2 is search type 2, 3 is search type 3, 4 is a write, and 5 is a mode load. Other values do nothing. A mode load stores req_mode_i at the accepting edge and does not raise busy. The mode fields are: bit0 VCI-disable, bit1 VPI-disable, bit2 type-3 valid compare value, bit3 duplicate-check enable, bit4 overwrite-check enable.
- R3: Search type 1 matches lines whose valid flag is 1 and whose VPI equals req_vpi_i. VCI is ignored.
- R4: Search type 2 matches lines whose valid flag is 1 and whose VPI and VCI both equal the key.
- R5: Search type 3 compares the valid flag with mode bit2. It leaves out VCI when bit0 is 1 and VPI when bit1 is 1. A compare value of 0 finds free lines. These mode bits have no effect on search types 1 and 2.
- R6: When several lines match, idx_o reports the lowest matching index and hit_o is 1. On a miss, hit_o is 0 and idx_o is 0.
- R7: A write with both checks off stores req_vpi_i, req_vci_i and req_vld_i into line req_addr_i.
- R8: With the duplicate check on, a write of a valid pattern is skipped and dup_fail_o is set in either of two cases: a valid line already holds the same VPI and VCI, or ext_hit_i is 1 in the check cycle.
- R9: With the overwrite check on, a write is skipped and occ_fail_o is set only when both the new pattern and the destination line are valid.
- R10: A search completes 2 edges after acceptance. A write that succeeds completes 2 edges after acceptance, plus one edge per enabled check. A failed check ends the write at the edge that evaluates it.
- R11: busy_o is 1 from the accepting edge until completion. Requests of any type that arrive while busy_o is 1 are dropped.
- R12: At completion, done_o is 1 for one cycle. A search loads hit_o and idx_o and clears both fail bits. A write clears hit_o, sets the one fail bit that applies (or none), and leaves idx_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Command code |
| req_vpi_i | input | VPI_W | Key or write VPI |
| req_vci_i | input | VCI_W | Key or write VCI |
| req_vld_i | input | 1 | Valid flag of the write pattern |
| req_addr_i | input | IDX_W | Write destination line |
| req_mode_i | input | 5 | Mode value for a mode load |
| ext_hit_i | input | 1 | Match indication from a second store, used by the duplicate check |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Last search found a line |
| idx_o | output | IDX_W | Lowest matching line of last search |
| dup_fail_o | output | 1 | Last write aborted as a duplicate |
| occ_fail_o | output | 1 | Last write aborted on an occupied line |

## Verification
Inputs are driven on the falling edge, so a request is accepted at the next rising edge. A search result, and the done pulse with it, is due two rising edges later. A write result is due after 2, 3 or 4 edges depending on the enabled checks, or earlier when a check fails. Each command task counts exactly that many edges and checks that busy_o stays high with done_o low before the due edge. At the falling edge after the due edge it checks that done_o is high, busy_o is low and the status matches. Effects of a skipped write or a dropped request are observed through follow-up searches.

// File: rtl/conn_cam_pkg.sv
package conn_cam_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_S1   = 3'd1,
    OP_S2   = 3'd2,
    OP_S3   = 3'd3,
    OP_WR   = 3'd4,
    OP_MODE = 3'd5
  } op_e;

  typedef struct packed {
    logic occ_en;
    logic dup_en;
    logic vset;
    logic vpi_dis;
    logic vci_dis;
  } mode_t;

  localparam mode_t MODE_RST = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRCH,
    ST_DUP,
    ST_OCC,
    ST_COMMIT
  } st_e;
endpackage

// File: rtl/conn_cam_match.sv
module conn_cam_match #(
  parameter int LINES = 8,
  parameter int VPI_W = 12,
  parameter int VCI_W = 16
) (
  input  logic [LINES-1:0]            line_vld_i,
  input  logic [LINES-1:0][VPI_W-1:0] line_vpi_i,
  input  logic [LINES-1:0][VCI_W-1:0] line_vci_i,
  input  logic [VPI_W-1:0]            key_vpi_i,
  input  logic [VCI_W-1:0]            key_vci_i,
  input  logic                        vset_i,
  input  logic                        use_vpi_i,
  input  logic                        use_vci_i,
  output logic [LINES-1:0]            match_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic vpi_eq, vci_eq;
    assign vpi_eq     = !use_vpi_i || (line_vpi_i[g] == key_vpi_i);
    assign vci_eq     = !use_vci_i || (line_vci_i[g] == key_vci_i);
    assign match_o[g] = (line_vld_i[g] == vset_i) && vpi_eq && vci_eq;
  end
endmodule

// File: rtl/conn_cam_prio.sv
module conn_cam_prio #(
  parameter  int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign hit_o = |req_i;
endmodule

// File: rtl/conn_cam_ctrl.sv
module conn_cam_ctrl
  import conn_cam_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  op_e  op_i,
  input  logic dup_en_i,
  input  logic occ_en_i,
  input  logic dup_hit_i,
  input  logic occ_hit_i,
  output st_e  state_o,
  output logic fin_srch_o,
  output logic fin_dup_o,
  output logic fin_occ_o,
  output logic commit_o
);
  st_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    fin_srch_o = 1'b0;
    fin_dup_o  = 1'b0;
    fin_occ_o  = 1'b0;
    commit_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept_i) begin
        if (op_i == OP_WR)
          state_d = dup_en_i ? ST_DUP : (occ_en_i ? ST_OCC : ST_COMMIT);
        else
          state_d = ST_SRCH;
      end
      ST_SRCH: begin
        fin_srch_o = 1'b1;
        state_d    = ST_IDLE;
      end
      ST_DUP: begin
        if (dup_hit_i) begin
          fin_dup_o = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          state_d = occ_en_i ? ST_OCC : ST_COMMIT;
        end
      end
      ST_OCC: begin
        if (occ_hit_i) begin
          fin_occ_o = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          state_d = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        commit_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/conn_cam.sv
module conn_cam
  import conn_cam_pkg::*;
#(
  parameter  int LINES = 8,
  parameter  int VPI_W = 12,
  parameter  int VCI_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_op_i,
  input  logic [VPI_W-1:0] req_vpi_i,
  input  logic [VCI_W-1:0] req_vci_i,
  input  logic             req_vld_i,
  input  logic [IDX_W-1:0] req_addr_i,
  input  logic [4:0]       req_mode_i,
  input  logic             ext_hit_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             dup_fail_o,
  output logic             occ_fail_o
);
  logic [LINES-1:0]            line_vld_q;
  logic [LINES-1:0][VPI_W-1:0] line_vpi_q;
  logic [LINES-1:0][VCI_W-1:0] line_vci_q;

  mode_t            mode_q;
  op_e              req_op, cmd_op_q;
  logic [VPI_W-1:0] cmd_vpi_q;
  logic [VCI_W-1:0] cmd_vci_q;
  logic             cmd_vld_q;
  logic [IDX_W-1:0] cmd_addr_q;

  st_e  state;
  logic idle, accept, mode_ld;
  logic fin_srch, fin_dup, fin_occ, commit;
  logic key_vset, use_vpi, use_vci;
  logic [LINES-1:0] match;
  logic             p_hit;
  logic [IDX_W-1:0] p_idx;
  logic dup_hit, occ_hit;

  assign req_op  = op_e'(req_op_i);
  assign idle    = (state == ST_IDLE);
  assign accept  = req_valid_i && idle &&
                   (req_op == OP_S1 || req_op == OP_S2 || req_op == OP_S3 || req_op == OP_WR);
  assign mode_ld = req_valid_i && idle && (req_op == OP_MODE);

  // compare setup: duplicate check always uses the full valid pattern
  always_comb begin
    key_vset = 1'b1;
    use_vpi  = 1'b1;
    use_vci  = 1'b1;
    if (state != ST_DUP) begin
      unique case (cmd_op_q)
        OP_S1: use_vci = 1'b0;
        OP_S3: begin
          key_vset = mode_q.vset;
          use_vpi  = !mode_q.vpi_dis;
          use_vci  = !mode_q.vci_dis;
        end
        default: ;
      endcase
    end
  end

  conn_cam_match #(.LINES(LINES), .VPI_W(VPI_W), .VCI_W(VCI_W)) u_match (
    .line_vld_i (line_vld_q),
    .line_vpi_i (line_vpi_q),
    .line_vci_i (line_vci_q),
    .key_vpi_i  (cmd_vpi_q),
    .key_vci_i  (cmd_vci_q),
    .vset_i     (key_vset),
    .use_vpi_i  (use_vpi),
    .use_vci_i  (use_vci),
    .match_o    (match)
  );

  conn_cam_prio #(.LINES(LINES)) u_prio (
    .req_i (match),
    .hit_o (p_hit),
    .idx_o (p_idx)
  );

  assign dup_hit = cmd_vld_q && (p_hit || ext_hit_i);
  assign occ_hit = cmd_vld_q && line_vld_q[cmd_addr_q];

  conn_cam_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .op_i       (req_op),
    .dup_en_i   (mode_q.dup_en),
    .occ_en_i   (mode_q.occ_en),
    .dup_hit_i  (dup_hit),
    .occ_hit_i  (occ_hit),
    .state_o    (state),
    .fin_srch_o (fin_srch),
    .fin_dup_o  (fin_dup),
    .fin_occ_o  (fin_occ),
    .commit_o   (commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_RST;
      cmd_op_q   <= OP_NOP;
      cmd_vpi_q  <= '0;
      cmd_vci_q  <= '0;
      cmd_vld_q  <= 1'b0;
      cmd_addr_q <= '0;
    end else begin
      if (mode_ld) mode_q <= mode_t'(req_mode_i);
      if (accept) begin
        cmd_op_q   <= req_op;
        cmd_vpi_q  <= req_vpi_i;
        cmd_vci_q  <= req_vci_i;
        cmd_vld_q  <= req_vld_i;
        cmd_addr_q <= req_addr_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_vld_q <= '0;
      line_vpi_q <= '0;
      line_vci_q <= '0;
    end else if (commit) begin
      line_vld_q[cmd_addr_q] <= cmd_vld_q;
      line_vpi_q[cmd_addr_q] <= cmd_vpi_q;
      line_vci_q[cmd_addr_q] <= cmd_vci_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      hit_o      <= 1'b0;
      idx_o      <= '0;
      dup_fail_o <= 1'b0;
      occ_fail_o <= 1'b0;
    end else begin
      done_o <= fin_srch || fin_dup || fin_occ || commit;
      if (fin_srch) begin
        hit_o      <= p_hit;
        idx_o      <= p_idx;
        dup_fail_o <= 1'b0;
        occ_fail_o <= 1'b0;
      end else if (fin_dup || fin_occ || commit) begin
        hit_o      <= 1'b0;
        dup_fail_o <= fin_dup;
        occ_fail_o <= fin_occ;
      end
    end
  end

  assign busy_o = !idle;
endmodule

// File: rtl/conn_cam_sva.sv
module conn_cam_sva #(
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [2:0]       req_op_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             hit_o,
  input logic [IDX_W-1:0] idx_o,
  input logic             dup_fail_o,
  input logic             occ_fail_o
);
  assert_busy_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && req_op_i >= 3'd1 && req_op_i <= 3'd4) |=> busy_o);

  assert_busy_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_status_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({hit_o, idx_o, dup_fail_o, occ_fail_o}));

  assert_fail_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dup_fail_o && occ_fail_o));

  assert_hit_nofail_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !(dup_fail_o || occ_fail_o));
endmodule

bind conn_cam conn_cam_sva #(.IDX_W(IDX_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .hit_o       (hit_o),
  .idx_o       (idx_o),
  .dup_fail_o  (dup_fail_o),
  .occ_fail_o  (occ_fail_o)
);

// File: tb/conn_cam_tb.sv
module conn_cam_tb;
  localparam int LINES = 8;
  localparam int VPI_W = 12;
  localparam int VCI_W = 16;
  localparam int IDX_W = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [2:0]       req_op_i = '0;
  logic [VPI_W-1:0] req_vpi_i = '0;
  logic [VCI_W-1:0] req_vci_i = '0;
  logic             req_vld_i = 1'b0;
  logic [IDX_W-1:0] req_addr_i = '0;
  logic [4:0]       req_mode_i = '0;
  logic             ext_hit_i = 1'b0;
  logic             busy_o, done_o, hit_o, dup_fail_o, occ_fail_o;
  logic [IDX_W-1:0] idx_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  conn_cam #(.LINES(LINES), .VPI_W(VPI_W), .VCI_W(VCI_W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one request; for lat>0 count edges to completion and check the pulse
  task automatic cmd(input logic [2:0] op, input int vpi, input int vci, input bit vld,
                     input int addr, input int mode, input int lat, input string req);
    bit ok;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_op_i    = op;
    req_vpi_i   = VPI_W'(vpi);
    req_vci_i   = VCI_W'(vci);
    req_vld_i   = vld;
    req_addr_i  = IDX_W'(addr);
    req_mode_i  = 5'(mode);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (lat > 0) begin
      ok = 1'b1;
      for (int e = 1; e < lat; e++) begin
        if (!busy_o || done_o) ok = 1'b0;
        @(negedge clk_i);
      end
      chk(ok && done_o && !busy_o, {req, " latency"}, {busy_o, done_o}, 2'b01);
    end
  endtask

  task automatic srch(input logic [2:0] op, input int vpi, input int vci,
                      input bit ehit, input int eidx, input string req);
    cmd(op, vpi, vci, 1'b0, 0, 0, 2, req);
    chk(hit_o == ehit, {req, " hit"}, hit_o, ehit);
    if (ehit) chk(idx_o == IDX_W'(eidx), {req, " idx"}, idx_o, eidx);
    chk(!dup_fail_o && !occ_fail_o, {req, " fails clear"}, {dup_fail_o, occ_fail_o}, 0);
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o, "R1 busy/done", {busy_o, done_o}, 0);
    chk(!hit_o && !dup_fail_o && !occ_fail_o, "R1 status", {hit_o, dup_fail_o, occ_fail_o}, 0);
    // default mode: type 3 finds valid lines only -> miss on empty store
    srch(3'd3, 0, 0, 1'b0, 0, "R1 default mode");
  endtask

  task automatic t_free;
    cmd(3'd5, 0, 0, 0, 0, 5'b00000, 0, "R2");
    srch(3'd3, 0, 0, 1'b1, 0, "R5 free unmasked");
    cmd(3'd5, 0, 0, 0, 0, 5'b00011, 0, "R2");
    srch(3'd3, 33, 44, 1'b1, 0, "R5 free masked");
    cmd(3'd5, 0, 0, 0, 0, 5'b00100, 0, "R2");
  endtask

  task automatic t_write;
    cmd(3'd4, 5, 100, 1'b1, 2, 0, 2, "R7 R10 write");
    chk(!hit_o && !dup_fail_o && !occ_fail_o, "R12 write status",
        {hit_o, dup_fail_o, occ_fail_o}, 0);
    cmd(3'd4, 5, 200, 1'b1, 5, 0, 2, "R7 write");
    cmd(3'd4, 7, 100, 1'b1, 6, 0, 2, "R7 write");
    srch(3'd2, 7, 100, 1'b1, 6, "R7 readback");
  endtask

  task automatic t_s1;
    srch(3'd1, 5, 999, 1'b1, 2, "R3 R6 lowest");
    srch(3'd1, 9, 100, 1'b0, 0, "R3 miss");
    chk(idx_o == 0, "R6 miss idx", idx_o, 0);
  endtask

  task automatic t_s2;
    srch(3'd2, 5, 200, 1'b1, 5, "R4 both fields");
    srch(3'd2, 5, 300, 1'b0, 0, "R4 vci differs");
  endtask

  task automatic t_s3;
    cmd(3'd5, 0, 0, 0, 0, 5'b00101, 0, "R2");
    srch(3'd3, 7, 0, 1'b1, 6, "R5 vci disabled");
    cmd(3'd5, 0, 0, 0, 0, 5'b00110, 0, "R2");
    srch(3'd3, 0, 100, 1'b1, 2, "R5 vpi disabled");
    srch(3'd2, 0, 100, 1'b0, 0, "R5 no effect on type 2");
    cmd(3'd5, 0, 0, 0, 0, 5'b00011, 0, "R2");
    srch(3'd3, 1, 1, 1'b1, 0, "R5 first free line");
    srch(3'd1, 7, 0, 1'b1, 6, "R5 no effect on type 1");
    cmd(3'd5, 0, 0, 0, 0, 5'b00100, 0, "R2");
  endtask

  task automatic t_dup;
    cmd(3'd5, 0, 0, 0, 0, 5'b01100, 0, "R2");
    cmd(3'd4, 5, 200, 1'b1, 3, 0, 2, "R8 R10 dup abort");
    chk(dup_fail_o && !occ_fail_o && !hit_o, "R8 dup status",
        {hit_o, dup_fail_o, occ_fail_o}, 3'b010);
    srch(3'd2, 5, 200, 1'b1, 5, "R8 line 3 untouched");
    ext_hit_i = 1'b1;
    cmd(3'd4, 8, 1, 1'b1, 3, 0, 2, "R8 ext abort");
    ext_hit_i = 1'b0;
    chk(dup_fail_o, "R8 ext status", dup_fail_o, 1);
    cmd(3'd4, 8, 1, 1'b1, 3, 0, 3, "R8 R10 dup pass");
    chk(!dup_fail_o, "R8 pass status", dup_fail_o, 0);
    srch(3'd2, 8, 1, 1'b1, 3, "R8 written");
  endtask

  task automatic t_occ;
    cmd(3'd5, 0, 0, 0, 0, 5'b10100, 0, "R2");
    cmd(3'd4, 9, 9, 1'b1, 3, 0, 2, "R9 R10 occ abort");
    chk(occ_fail_o && !dup_fail_o, "R9 occ status", {dup_fail_o, occ_fail_o}, 2'b01);
    srch(3'd2, 8, 1, 1'b1, 3, "R9 line kept");
    cmd(3'd4, 0, 0, 1'b0, 3, 0, 3, "R9 invalid over valid");
    chk(!occ_fail_o, "R9 invalid allowed", occ_fail_o, 0);
    srch(3'd2, 8, 1, 1'b0, 0, "R9 line cleared");
    cmd(3'd4, 9, 9, 1'b1, 4, 0, 3, "R9 valid over free");
    srch(3'd2, 9, 9, 1'b1, 4, "R9 written");
  endtask

  task automatic t_both;
    cmd(3'd5, 0, 0, 0, 0, 5'b11100, 0, "R2");
    cmd(3'd4, 1, 1, 1'b1, 7, 0, 4, "R10 both checks");
    srch(3'd2, 1, 1, 1'b1, 7, "R10 written");
  endtask

  task automatic t_busy;
    // mode stays 11100: four-edge write
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = 3'd4; req_vpi_i = 2; req_vci_i = 2;
    req_vld_i = 1'b1; req_addr_i = 0;
    @(negedge clk_i);
    req_op_i = 3'd2; req_vpi_i = 5; req_vci_i = 200;
    @(negedge clk_i);
    req_op_i = 3'd5; req_mode_i = 5'b00000;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(busy_o && !done_o, "R11 still busy", {busy_o, done_o}, 2'b10);
    @(negedge clk_i);
    chk(done_o && !busy_o && !hit_o, "R11 write completes", {done_o, busy_o, hit_o}, 3'b100);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(!done_o && !busy_o, "R11 dropped search", {done_o, busy_o}, 0);
    end
    srch(3'd3, 2, 2, 1'b1, 0, "R11 mode load dropped");
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = 3'd6;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(!busy_o, "R2 unused code", busy_o, 0);
    @(negedge clk_i);
    chk(!done_o, "R2 unused code done", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_free;
    t_write;
    t_s1;
    t_s2;
    t_s3;
    t_dup;
    t_occ;
    t_both;
    t_busy;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule